// File: doc/BRIEF.md
# Synchronous Serial Transmit Master with Data/Command Sideband

This block is a transmit-only synchronous serial master driven through a small register window. Software pushes characters into a 16-entry transmit FIFO. The block shifts each character out on a bit clock, a data line and a chip-select line. Each FIFO entry also carries one data/command level. That level drives a dedicated sideband pin for exactly as long as its own character is on the wire. A display controller can therefore take command and data bytes from the same stream without software waiting for the line to go idle.

The character length runs from 2 to 32 bits. Clock polarity, clock phase, chip-select level and the order of bits and bytes on the wire are all programmable. A clock divider sets the bit rate. A status word reports FIFO occupancy, full and threshold flags, activity and a sticky underrun flag.

Top module: `sstx_top`

## Requirements
- R1: A write to offset 0x00 pushes one entry: the low L bits of the write data are the character, and bit 16 is its data/command level. A write while 16 entries are held is dropped, the occupancy does not change and no flag is raised.
- R2: `gpc_o` shows the data/command level of the character being shifted, for every sampled bit of that character.
- R3: The character length is L = field + 2, where the field is offset 0x08 bits [7:3]. Field values 30 and 31 both give L = 32.
- R4: With divider D (offset 0x18 bits [7:0]), each half of a bit lasts D+1 clock cycles. Consecutive sample edges are therefore 2(D+1) cycles apart, across character boundaries too.
- R5: Offset 0x08 bit 0 sets the idle level of `sck_o`. Bit 1 sets the phase. With phase 0, data changes on the trailing edge and is sampled on the leading edge. With phase 1, data changes on the leading edge and is sampled on the trailing edge.
- R6: While offset 0x04 bit 15 is 0, no character leaves the FIFO, and writes to the FIFO are still accepted. Setting the bit starts transmission of what the FIFO holds.
- R7: Writing 1 to offset 0x04 bit 2 empties the FIFO. The bit reads back as 0, and the discarded entries are never sent.
- R8: Status at offset 0x0c: bits [23:16] give the occupancy, bit 5 is set when the FIFO is full, and bit 3 is set when the occupancy is at or below the threshold in offset 0x08 bits [19:16]. After reset the status reads 0x00000008.
- R9: Offset 0x04 bits [19:18] set the wire order: 00 = high byte first with high bit first, 01 = high byte first with low bit first, 10 = low byte first with low bit first, 11 = low byte first with high bit first. A partial top byte holds bits L-1 down to 8·floor((L-1)/8).
- R10: Offset 0x08 bit 30 sets the chip-select active level, where 0 means active low. Chip-select is asserted half a bit before the first bit, stays asserted across back-to-back characters, and is released D+1 cycles after the final clock edge. Status bit 6 (busy) is set while chip-select is asserted.
- R11: Status bit 1 (underrun) is set when a character finishes, the FIFO is empty and the channel is enabled. It never sets while the channel is disabled. A status write with bit 1 = 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| sck_o | output | 1 | Serial bit clock |
| mosi_o | output | 1 | Serial data out |
| cs_o | output | 1 | Chip-select |
| gpc_o | output | 1 | Data/command level of the current character |

## Verification
The hardest case to reach is the handover from one character to the next. The last bit of a character ends, the FIFO head is popped, and the sideband level may flip, all in the same cycle and with chip-select held. To reach it, the bench writes characters faster than they drain and alternates their data/command levels. It then checks the bit stream, the sideband level seen at every sample edge, the sample spacing and the count of chip-select assertions. Runs are repeated in both phase modes, in all four wire orders and at both length limits.

// File: rtl/sstx_pkg.sv
package sstx_pkg;

  localparam int unsigned CHAR_W = 32;

  localparam logic [4:0] A_DATA = 5'h00;
  localparam logic [4:0] A_CTL0 = 5'h04;
  localparam logic [4:0] A_CTL1 = 5'h08;
  localparam logic [4:0] A_STAT = 5'h0c;
  localparam logic [4:0] A_CDIV = 5'h18;

  typedef enum logic [1:0] {
    ORD_HB_HB = 2'b00,
    ORD_HB_LB = 2'b01,
    ORD_LB_LB = 2'b10,
    ORD_LB_HB = 2'b11
  } order_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL
  } tx_state_e;

  typedef struct packed {
    logic [5:0] len;
    order_e     order;
    logic       cpha;
    logic       cpol;
    logic       cs_hi;
  } tx_cfg_t;

  function automatic logic [5:0] len_from_field(logic [4:0] f);
    return (f > 5'd30) ? 6'd32 : ({1'b0, f} + 6'd2);
  endfunction

  // character bit sent at wire position idx
  function automatic logic [4:0] src_bit(order_e ord, logic [5:0] len, logic [4:0] idx);
    logic [5:0] last, pos, top;
    last = len - 6'd1;
    pos  = {1'b0, idx};
    top  = '0;
    case (ord)
      ORD_HB_HB: pos = last - {1'b0, idx};
      ORD_LB_LB: pos = {1'b0, idx};
      default: begin
        // high-byte/low-bit is the reverse of low-byte/high-bit
        if (ord == ORD_HB_LB) pos = last - {1'b0, idx};
        top = {1'b0, pos[4:3], 3'b111};
        if (top > last) top = last;
        pos = top - {3'b000, pos[2:0]};
      end
    endcase
    return pos[4:0];
  endfunction

endpackage

// File: rtl/sstx_fifo.sv
module sstx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 33
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   push_i,
  input  logic [W-1:0]           wdata_i,
  input  logic                   pop_i,
  input  logic                   flush_i,
  output logic [W-1:0]           rdata_o,
  output logic [$clog2(DEPTH):0] count_o,
  output logic                   full_o,
  output logic                   empty_o
);
  localparam int unsigned PTR_W = $clog2(DEPTH);
  localparam int unsigned CNT_W = PTR_W + 1;

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, rptr_q;
  logic [CNT_W-1:0] count_q;
  logic             do_push, do_pop;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i && !full_o && !flush_i;
  assign do_pop  = pop_i && !empty_o && !flush_i;
  assign rdata_o = mem_q[rptr_q];
  assign count_o = count_q;

  function automatic logic [PTR_W-1:0] inc(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else if (flush_i) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      count_q <= '0;
    end else begin
      if (do_push) wptr_q <= inc(wptr_q);
      if (do_pop)  rptr_q <= inc(rptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wptr_q] <= wdata_i;
  end

  p_no_overflow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNT_W'(DEPTH));
  p_full_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (count_q == CNT_W'(DEPTH)));
  p_flush_empties_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (count_q == '0));
  p_pop_nonempty_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);

endmodule

// File: rtl/sstx_regs.sv
module sstx_regs
  import sstx_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DIV_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [4:0]             addr_i,
  input  logic [31:0]            wdata_i,
  input  logic [$clog2(DEPTH):0] fifo_count_i,
  input  logic                   fifo_full_i,
  input  logic                   busy_i,
  input  logic                   underrun_set_i,
  output tx_cfg_t                cfg_o,
  output logic                   en_o,
  output logic [DIV_W-1:0]       div_o,
  output logic                   push_o,
  output logic [CHAR_W:0]        push_data_o,
  output logic                   flush_o,
  output logic [31:0]            rdata_o
);
  logic             en_q, cs_hi_q, cpha_q, cpol_q, unr_q;
  logic [1:0]       order_q;
  logic [3:0]       thr_q;
  logic [4:0]       lenf_q;
  logic [DIV_W-1:0] div_q;
  logic [5:0]       len;
  logic [31:0]      mask;
  logic             half_empty;

  assign len     = len_from_field(lenf_q);
  assign mask    = ~(32'hFFFF_FFFE << (len - 6'd1));
  assign cfg_o   = '{len: len, order: order_e'(order_q), cpha: cpha_q, cpol: cpol_q, cs_hi: cs_hi_q};
  assign en_o    = en_q;
  assign div_o   = div_q;
  assign push_o  = we_i && (addr_i == A_DATA);
  assign push_data_o = {wdata_i[16], wdata_i & mask};
  assign flush_o = we_i && (addr_i == A_CTL0) && wdata_i[2];
  assign half_empty = (32'(fifo_count_i) <= 32'(thr_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      order_q <= 2'b00;
      cs_hi_q <= 1'b0;
      thr_q   <= '0;
      lenf_q  <= 5'd6;
      cpha_q  <= 1'b0;
      cpol_q  <= 1'b0;
      div_q   <= '0;
      unr_q   <= 1'b0;
    end else begin
      if (we_i && addr_i == A_CTL0) begin
        en_q    <= wdata_i[15];
        order_q <= wdata_i[19:18];
      end
      if (we_i && addr_i == A_CTL1) begin
        cs_hi_q <= wdata_i[30];
        thr_q   <= wdata_i[19:16];
        lenf_q  <= wdata_i[7:3];
        cpha_q  <= wdata_i[1];
        cpol_q  <= wdata_i[0];
      end
      if (we_i && addr_i == A_CDIV) div_q <= wdata_i[DIV_W-1:0];
      if (underrun_set_i) unr_q <= 1'b1;
      else if (we_i && addr_i == A_STAT && !wdata_i[1]) unr_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTL0: begin
        rdata_o[19:18] = order_q;
        rdata_o[15]    = en_q;
      end
      A_CTL1: begin
        rdata_o[30]    = cs_hi_q;
        rdata_o[19:16] = thr_q;
        rdata_o[7:3]   = lenf_q;
        rdata_o[1]     = cpha_q;
        rdata_o[0]     = cpol_q;
      end
      A_STAT: begin
        rdata_o[23:16] = 8'(fifo_count_i);
        rdata_o[6]     = busy_i;
        rdata_o[5]     = fifo_full_i;
        rdata_o[3]     = half_empty;
        rdata_o[1]     = unr_q;
      end
      A_CDIV: rdata_o[DIV_W-1:0] = div_q;
      default: rdata_o = '0;
    endcase
  end

  p_underrun_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_set_i |-> en_q);

endmodule

// File: rtl/sstx_shifter.sv
module sstx_shifter
  import sstx_pkg::*;
#(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  tx_cfg_t          cfg_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             flush_i,
  input  logic             fifo_empty_i,
  input  logic [CHAR_W:0]  fifo_rdata_i,
  output logic             pop_o,
  output logic             busy_o,
  output logic             underrun_set_o,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             cs_o,
  output logic             gpc_o
);
  tx_state_e        state_q;
  logic [DIV_W-1:0] hcnt_q;
  logic             half_q, dc_q;
  logic [4:0]       bit_q;
  logic [CHAR_W-1:0] shreg_q;
  logic             tick, can_load, last_bit, char_end, active;

  assign tick     = (hcnt_q == '0);
  assign can_load = en_i && !fifo_empty_i && !flush_i;
  assign last_bit = ({1'b0, bit_q} == (cfg_i.len - 6'd1));
  assign char_end = (state_q == ST_SHIFT) && tick && half_q && last_bit;
  assign pop_o    = ((state_q == ST_IDLE) || char_end) && can_load;
  assign underrun_set_o = char_end && !can_load && en_i;
  assign active   = (state_q != ST_IDLE);
  assign busy_o   = active;
  assign cs_o     = cfg_i.cs_hi ? active : !active;
  assign gpc_o    = dc_q;
  assign sck_o    = cfg_i.cpol ^ ((state_q == ST_SHIFT) && (half_q != cfg_i.cpha));
  assign mosi_o   = ((state_q == ST_LEAD) || (state_q == ST_SHIFT)) ?
                    shreg_q[src_bit(cfg_i.order, cfg_i.len, bit_q)] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      hcnt_q  <= '0;
      half_q  <= 1'b0;
      bit_q   <= '0;
      shreg_q <= '0;
      dc_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (can_load) begin
            state_q <= ST_LEAD;
            hcnt_q  <= div_i;
            bit_q   <= '0;
            half_q  <= 1'b0;
            shreg_q <= fifo_rdata_i[CHAR_W-1:0];
            dc_q    <= fifo_rdata_i[CHAR_W];
          end
        end
        ST_LEAD: begin
          if (tick) begin
            state_q <= ST_SHIFT;
            hcnt_q  <= div_i;
          end else hcnt_q <= hcnt_q - 1'b1;
        end
        ST_SHIFT: begin
          if (tick) begin
            hcnt_q <= div_i;
            half_q <= !half_q;
            if (half_q) begin
              if (!last_bit) bit_q <= bit_q + 1'b1;
              else if (can_load) begin
                bit_q   <= '0;
                shreg_q <= fifo_rdata_i[CHAR_W-1:0];
                dc_q    <= fifo_rdata_i[CHAR_W];
              end else state_q <= ST_TAIL;
            end
          end else hcnt_q <= hcnt_q - 1'b1;
        end
        ST_TAIL: begin
          if (tick) state_q <= ST_IDLE;
          else hcnt_q <= hcnt_q - 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  p_dc_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !char_end) |=> $stable(dc_q));
  p_bit_in_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT) |-> ({1'b0, bit_q} < cfg_i.len));

endmodule

// File: rtl/sstx_top.sv
module sstx_top
  import sstx_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 16,
  parameter int unsigned DIV_W      = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        sck_o,
  output logic        mosi_o,
  output logic        cs_o,
  output logic        gpc_o
);
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH) + 1;

  tx_cfg_t          cfg;
  logic             en, push, flush, pop, busy, unr_set, full, empty;
  logic [DIV_W-1:0] div;
  logic [CHAR_W:0]  push_data, head;
  logic [CNT_W-1:0] count;

  sstx_regs #(.DEPTH(FIFO_DEPTH), .DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .fifo_count_i(count), .fifo_full_i(full), .busy_i(busy),
    .underrun_set_i(unr_set),
    .cfg_o(cfg), .en_o(en), .div_o(div), .push_o(push),
    .push_data_o(push_data), .flush_o(flush), .rdata_o(reg_rdata_o)
  );

  sstx_fifo #(.DEPTH(FIFO_DEPTH), .W(CHAR_W + 1)) u_fifo (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(push_data), .pop_i(pop), .flush_i(flush),
    .rdata_o(head), .count_o(count), .full_o(full), .empty_o(empty)
  );

  sstx_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .en_i(en), .cfg_i(cfg), .div_i(div), .flush_i(flush),
    .fifo_empty_i(empty), .fifo_rdata_i(head),
    .pop_o(pop), .busy_o(busy), .underrun_set_o(unr_set),
    .sck_o, .mosi_o, .cs_o, .gpc_o
  );

endmodule

// File: tb/sstx_top_tb.sv
module sstx_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sck, mosi, cs, gpc;

  sstx_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .cs_o(cs), .gpc_o(gpc)
  );

  int total = 0;
  int bad = 0;
  bit done = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // receiver model
  bit mon_pol = 0, mon_pha = 0, mon_cs_hi = 0;
  bit prev_sck = 0, prev_csa = 0;
  bit rx_bits [0:255];
  bit rx_dc   [0:255];
  int rx_n, edge_n, cs_asserts, first_edge, last_edge, cs_rise, cs_fall;
  int last_samp, gap_min, gap_max;

  always @(negedge clk) begin
    bit csa, lead, samp;
    csa = (cs == mon_cs_hi);
    if (rst_n) begin
      if (csa && !prev_csa) begin cs_rise = cyc; cs_asserts++; end
      if (!csa && prev_csa) cs_fall = cyc;
      if (sck != prev_sck) begin
        if (edge_n == 0) first_edge = cyc;
        last_edge = cyc;
        edge_n++;
        lead = (prev_sck == mon_pol);
        samp = mon_pha ? !lead : lead;
        if (samp && rx_n < 256) begin
          if (last_samp >= 0) begin
            if (cyc - last_samp < gap_min) gap_min = cyc - last_samp;
            if (cyc - last_samp > gap_max) gap_max = cyc - last_samp;
          end
          last_samp = cyc;
          rx_bits[rx_n] = mosi;
          rx_dc[rx_n] = gpc;
          rx_n++;
        end
      end
    end
    prev_sck = sck;
    prev_csa = csa;
  end

  bit exp_bits [0:255];
  bit exp_dc   [0:255];
  int exp_n;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1;
    rx_n = 0; edge_n = 0; cs_asserts = 0; first_edge = -1; last_edge = -1;
    cs_rise = -1; cs_fall = -1; last_samp = -1; gap_min = 1 << 30; gap_max = 0;
    exp_n = 0;
  endtask

  task automatic reg_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic reg_rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_cfg(input int lenf, input bit pol, input bit pha,
                         input bit cs_hi, input int div);
    reg_wr(5'h18, 32'(div));
    reg_wr(5'h08, (32'(cs_hi) << 30) | (32'd7 << 16) | (32'(lenf) << 3) |
                  (32'(pha) << 1) | 32'(pol));
    mon_pol = pol; mon_pha = pha; mon_cs_hi = cs_hi;
  endtask

  task automatic set_ctl0(input bit en, input int ord);
    reg_wr(5'h04, (32'(ord) << 18) | (32'(en) << 15));
  endtask

  // expected wire stream built byte by byte
  task automatic exp_add(input logic [31:0] word, input int len, input int ord, input bit dc);
    int nb;
    nb = (len + 7) / 8;
    for (int s = 0; s < nb; s++) begin
      int k, w;
      k = (ord < 2) ? nb - 1 - s : s;
      w = (len - 8 * k < 8) ? len - 8 * k : 8;
      for (int t = 0; t < w; t++) begin
        int j;
        j = (ord == 0 || ord == 3) ? w - 1 - t : t;
        exp_bits[exp_n] = word[8 * k + j];
        exp_dc[exp_n] = dc;
        exp_n++;
      end
    end
  endtask

  task automatic wait_done();
    logic [31:0] st;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(5'h0c, st);
      if (!st[6] && st[23:16] == 0) break;
    end
    repeat (4) @(posedge clk);
  endtask

  task automatic cmp_stream(input string req);
    int eb, ed;
    eb = 0; ed = 0;
    chk(rx_n == exp_n, req, "bit count", rx_n, exp_n);
    for (int i = 0; i < exp_n && i < rx_n; i++) begin
      if (rx_bits[i] != exp_bits[i]) eb++;
      if (rx_dc[i] != exp_dc[i]) ed++;
    end
    chk(eb == 0, req, "data bit mismatches", eb, 0);
    chk(ed == 0, "R2", "dc level mismatches", ed, 0);
  endtask

  task automatic t_reset();
    logic [31:0] st;
    reg_rd(5'h0c, st);
    chk(st == 32'h8, "R8", "status after reset", st, 32'h8);
    chk(cs == 1'b1, "R10", "cs idle (active low)", cs, 1);
    chk(sck == 1'b0, "R5", "sck idle low", sck, 0);
    chk(gpc == 1'b0, "R2", "gpc after reset", gpc, 0);
  endtask

  task automatic t_basic();
    logic [31:0] st;
    set_cfg(6, 0, 0, 0, 2);
    set_ctl0(1, 0);
    clear_mon();
    reg_wr(5'h00, 32'h1_00A5); exp_add(32'hA5, 8, 0, 1);
    reg_wr(5'h00, 32'h0_003C); exp_add(32'h3C, 8, 0, 0);
    reg_wr(5'h00, 32'h1_0081); exp_add(32'h81, 8, 0, 1);
    reg_rd(5'h0c, st);
    chk(st[6] == 1'b1, "R10", "busy during burst", st[6], 1);
    chk(cs == 1'b0, "R10", "cs asserted during burst", cs, 0);
    wait_done();
    cmp_stream("R1");
    chk(cs_asserts == 1, "R10", "cs asserts in burst", cs_asserts, 1);
    chk(first_edge - cs_rise == 6, "R10", "lead time", first_edge - cs_rise, 6);
    chk(cs_fall - last_edge == 3, "R10", "tail time", cs_fall - last_edge, 3);
    chk(gap_min == 6 && gap_max == 6, "R4", "sample spacing", gap_max, 6);
    reg_rd(5'h0c, st);
    chk(st[1] == 1'b1, "R11", "underrun after drain", st[1], 1);
    chk(st[6] == 1'b0, "R10", "busy clear after release", st[6], 0);
  endtask

  task automatic t_underrun_clear();
    logic [31:0] st;
    reg_wr(5'h0c, 32'h0);
    reg_rd(5'h0c, st);
    chk(st[1] == 1'b0, "R11", "underrun cleared", st[1], 0);
  endtask

  task automatic t_mode3();
    set_cfg(10, 1, 1, 0, 0);
    set_ctl0(1, 0);
    repeat (2) @(posedge clk);
    chk(sck == 1'b1, "R5", "sck idle high", sck, 1);
    clear_mon();
    reg_wr(5'h00, 32'h1_0A53); exp_add(32'hA53, 12, 0, 1);
    reg_wr(5'h00, 32'h0_05C6); exp_add(32'h5C6, 12, 0, 0);
    wait_done();
    cmp_stream("R5");
    chk(first_edge - cs_rise == 1, "R5", "phase1 lead time", first_edge - cs_rise, 1);
    chk(gap_min == 2 && gap_max == 2, "R4", "div0 sample spacing", gap_max, 2);
    chk(cs_asserts == 1, "R10", "cs continuous mode3", cs_asserts, 1);
  endtask

  task automatic t_orders();
    for (int o = 0; o < 4; o++) begin
      set_cfg(10, 0, 0, 0, 1);
      set_ctl0(1, o);
      clear_mon();
      reg_wr(5'h00, 32'h1_0A53); exp_add(32'hA53, 12, o, 1);
      reg_wr(5'h00, 32'h0_0E1D); exp_add(32'hE1D, 12, o, 0);
      wait_done();
      cmp_stream("R9");
    end
  endtask

  task automatic t_lengths();
    set_cfg(31, 0, 0, 1, 0);
    set_ctl0(1, 0);
    clear_mon();
    reg_wr(5'h00, 32'hDEAD_BEEF); exp_add(32'hDEAD_BEEF, 32, 0, 1);
    wait_done();
    cmp_stream("R3");
    chk(cs_asserts == 1, "R10", "active-high cs", cs_asserts, 1);
    set_cfg(0, 0, 0, 0, 0);
    set_ctl0(1, 2);
    clear_mon();
    reg_wr(5'h00, 32'h1_FFFE); exp_add(32'h2, 2, 2, 1);
    wait_done();
    cmp_stream("R3");
  endtask

  task automatic t_disabled();
    logic [31:0] st;
    set_cfg(6, 0, 0, 0, 1);
    set_ctl0(0, 0);
    reg_wr(5'h0c, 32'h0);
    clear_mon();
    reg_wr(5'h00, 32'h0_0011); exp_add(32'h11, 8, 0, 0);
    reg_wr(5'h00, 32'h1_00EE); exp_add(32'hEE, 8, 0, 1);
    repeat (100) @(posedge clk);
    reg_rd(5'h0c, st);
    chk(edge_n == 0 && cs_asserts == 0, "R6", "activity while disabled", edge_n, 0);
    chk(st[23:16] == 2, "R6", "entries held while disabled", st[23:16], 2);
    chk(st[1] == 1'b0, "R11", "no underrun while disabled", st[1], 0);
    set_ctl0(1, 0);
    wait_done();
    cmp_stream("R6");
  endtask

  task automatic t_fill_flush();
    logic [31:0] st;
    set_cfg(6, 0, 0, 0, 1);
    set_ctl0(0, 0);
    for (int i = 0; i < 7; i++) reg_wr(5'h00, 32'(i));
    reg_rd(5'h0c, st);
    chk(st[23:16] == 7 && st[3], "R8", "count 7 at threshold", st, 32'h0007_0008);
    reg_wr(5'h00, 32'h7);
    reg_rd(5'h0c, st);
    chk(st[23:16] == 8 && !st[3], "R8", "count 8 above threshold", st, 32'h0008_0000);
    for (int i = 0; i < 8; i++) reg_wr(5'h00, 32'(i));
    reg_rd(5'h0c, st);
    chk(st[23:16] == 16 && st[5], "R8", "full at 16", st, 32'h0010_0020);
    reg_wr(5'h00, 32'h55);
    reg_rd(5'h0c, st);
    chk(st[23:16] == 16, "R1", "write while full dropped", st[23:16], 16);
    reg_wr(5'h04, 32'h4);
    reg_rd(5'h0c, st);
    chk(st[23:16] == 0 && !st[5], "R7", "flush empties", st, 32'h8);
    reg_rd(5'h04, st);
    chk(st[2] == 1'b0, "R7", "flush reads back 0", st[2], 0);
    clear_mon();
    set_ctl0(1, 0);
    repeat (60) @(posedge clk);
    chk(edge_n == 0, "R7", "flushed entries not sent", edge_n, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_basic();
    t_underrun_clear();
    t_mode3();
    t_orders();
    t_lengths();
    t_disabled();
    t_fill_flush();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule